// File: doc/BRIEF.md
# Cascadable Serial Code Loader for a 16-bit Converter

This block receives a 16-bit converter code over a three-wire serial link (shift clock, data, load strobe) and holds it for the converter. Bits are sampled on rising shift-clock edges, most significant bit first. A rising edge on the load strobe copies the assembled word into the held code register. The code register keeps its value until the next strobe.

The top bit of the shift register is re-driven on a serial output. This lets several loaders be cascaded on one link. A second loader fed from this output receives the word that was shifted in before the current one. All three serial inputs are asynchronous to the system clock, so they pass through a synchronizer before their edges are detected.

An asynchronous clear drives the held code to the bottom of the span, which is code zero. Power-up reset gives the same state. A two-bit span select is decoded into a one-hot span indication and a current-versus-voltage flag.

Top module: `serial_dac_loader`

## Requirements
- R1: After reset, `code_out` is 0x0000 and `sdout` is 0.
- R2: On a rising edge of the synchronized `latch_in`, `code_out` takes the last 16 bits shifted in. The first bit shifted lands in bit 15 of the code.
- R3: Without a rising load strobe, `code_out` holds its value, even while shift-clock edges arrive or the strobe falls.
- R4: `sdout` equals bit 15 of the shift register. It updates only on falling edges of the synchronized shift clock. A downstream unit that samples `sdout` on rising shift-clock edges collects word N-1 while word N is shifted in.
- R5: While `clr_in` is high, `code_out` is 0x0000. The clear takes effect without waiting for a system clock edge.
- R6: A load strobe that rises while `clr_in` is high is ignored. `code_out` stays 0x0000 after the clear is released, and the shift register keeps its contents for a later strobe.
- R7: `range_sel` decodes one-hot into `range_onehot`: value 0 sets bit 0 (0–5 V), 1 sets bit 1 (4–20 mA), 2 sets bit 2 (0–20 mA), 3 sets bit 3 (0–24 mA). `range_is_current` is 1 for every value except 0.
- R8: If more than 16 bits are shifted before a strobe, only the last 16 are kept and loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| sdin_in | input | 1 | Serial data, asynchronous, MSB first |
| latch_in | input | 1 | Load strobe; a rising edge loads the code |
| clr_in | input | 1 | Asynchronous clear of the held code, active high |
| range_sel | input | 2 | Output span select |
| code_out | output | 16 | Held converter code |
| sdout | output | 1 | Cascade serial output |
| range_onehot | output | 4 | One-hot span indication |
| range_is_current | output | 1 | High for the current spans |

## Verification
The assertions assume the serial inputs change slowly compared with the system clock. Each level must last at least several system cycles, so that a shift-clock rise and fall never fall in the same detected cycle. Data must also be stable at the synchronizer output when the rising clock edge is detected there. The bench meets this by changing the data and the shift clock only on falling system-clock edges, with five system cycles between any two serial-input changes. It moves `clr_in` away from rising clock edges, and it holds `range_sel` still between its checks.

// File: rtl/serial_dac_loader_pkg.sv
package serial_dac_loader_pkg;

  typedef enum logic [1:0] {
    SPAN_V_0_5   = 2'b00,
    SPAN_I_4_20  = 2'b01,
    SPAN_I_0_20  = 2'b10,
    SPAN_I_0_24  = 2'b11
  } span_e;

  localparam int SPAN_COUNT = 4;

  // One-hot position of a span select value
  function automatic logic [SPAN_COUNT-1:0] span_to_onehot(input logic [1:0] sel);
    logic [SPAN_COUNT-1:0] r;
    r = '0;
    r[sel] = 1'b1;
    return r;
  endfunction

  // All spans except the voltage span are current spans
  function automatic logic span_is_current(input logic [1:0] sel);
    return span_e'(sel) != SPAN_V_0_5;
  endfunction

  // Next shift-register contents after one serial bit
  function automatic logic [15:0] shift_in_bit(input logic [15:0] cur, input logic b);
    return {cur[14:0], b};
  endfunction

endpackage

// File: rtl/sdl_input_sync.sv
module sdl_input_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  localparam int TOP = STAGES - 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe <= '0;
        last <= 1'b0;
      end else begin
        pipe <= {pipe[STAGES-2:0], async_in[i]};
        last <= pipe[TOP];
      end
    end

    assign sync_out[i] = pipe[TOP];
    assign rise[i]     = pipe[TOP] & ~last;
    assign fall[i]     = ~pipe[TOP] & last;
  end

endmodule

// File: rtl/sdl_shifter.sv
module sdl_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  input  logic         tap_en,
  output logic [W-1:0] word,
  output logic         sdout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {word[W-2:0], din};
    end
  end

  // Output moves on the falling shift edge, half a period ahead of the next sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdout <= 1'b0;
    end else if (tap_en) begin
      sdout <= word[W-1];
    end
  end

endmodule

// File: rtl/sdl_holder.sv
module sdl_holder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] code
);

  localparam logic [W-1:0] BOTTOM = '0;

  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n) begin
      code <= BOTTOM;
    end else if (clr) begin
      code <= BOTTOM;
    end else if (load) begin
      code <= word_in;
    end
  end

endmodule

// File: rtl/sdl_span_decode.sv
module sdl_span_decode
  import serial_dac_loader_pkg::*;
(
  input  logic [1:0]            sel,
  output logic [SPAN_COUNT-1:0] onehot,
  output logic                  is_current
);

  always_comb begin
    onehot     = span_to_onehot(sel);
    is_current = span_is_current(sel);
  end

endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader
  import serial_dac_loader_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              sdin_in,
  input  logic              latch_in,
  input  logic              clr_in,
  input  logic [1:0]        range_sel,
  output logic [WORD_W-1:0] code_out,
  output logic              sdout,
  output logic [3:0]        range_onehot,
  output logic              range_is_current
);

  localparam int SIG_SCLK  = 0;
  localparam int SIG_SDIN  = 1;
  localparam int SIG_LATCH = 2;
  localparam int NSIG      = 3;

  logic [NSIG-1:0]   raw_in;
  logic [NSIG-1:0]   syn;
  logic [NSIG-1:0]   syn_rise;
  logic [NSIG-1:0]   syn_fall;

  // Named internal events for the checker
  logic              sclk_rise;
  logic              sclk_fall;
  logic              latch_rise;
  logic              data_bit;
  logic [WORD_W-1:0] shreg_word;

  assign raw_in = {latch_in, sdin_in, sclk_in};

  sdl_input_sync #(.N(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_in),
    .sync_out (syn),
    .rise     (syn_rise),
    .fall     (syn_fall)
  );

  assign sclk_rise  = syn_rise[SIG_SCLK];
  assign sclk_fall  = syn_fall[SIG_SCLK];
  assign latch_rise = syn_rise[SIG_LATCH];
  assign data_bit   = syn[SIG_SDIN];

  sdl_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sclk_rise),
    .din      (data_bit),
    .tap_en   (sclk_fall),
    .word     (shreg_word),
    .sdout    (sdout)
  );

  sdl_holder #(.W(WORD_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_in),
    .load    (latch_rise),
    .word_in (shreg_word),
    .code    (code_out)
  );

  sdl_span_decode u_span (
    .sel        (range_sel),
    .onehot     (range_onehot),
    .is_current (range_is_current)
  );

endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         shift_fall,
  input logic         latch_rise,
  input logic [W-1:0] shreg,
  input logic [W-1:0] code,
  input logic         sdout,
  input logic [3:0]   range_onehot
);

  // R2: a load strobe copies the shift register into the code
  a_r2_load_word: assert property (@(posedge clk) disable iff (!rst_n || clr)
    latch_rise |=> code == $past(shreg));

  // R3: without a strobe the code does not move
  a_r3_hold_code: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !latch_rise |=> $stable(code));

  // R4: the cascade output follows the top shift bit on falling shift edges
  a_r4_sdout_msb: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fall |=> sdout == $past(shreg[W-1]));

  a_r4_sdout_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_fall |=> $stable(sdout));

  // R5: clear pins the code at the bottom of the span
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> code == '0);

  // R6: a strobe during clear leaves the code at zero
  a_r6_latch_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && latch_rise) |=> code == '0);

  // R7: exactly one span is indicated
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(range_onehot) == 1);

endmodule

bind serial_dac_loader sdl_checker #(.W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr          (clr_in),
  .shift_fall   (sclk_fall),
  .latch_rise   (latch_rise),
  .shreg        (shreg_word),
  .code         (code_out),
  .sdout        (sdout),
  .range_onehot (range_onehot)
);

// File: tb/serial_dac_loader_test.sv
`timescale 1ns/1ps
module serial_dac_loader_test;

  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_in = 1'b0;
  logic        sdin_in = 1'b0;
  logic        latch_in = 1'b0;
  logic        clr_in = 1'b0;
  logic [1:0]  range_sel = 2'b00;
  logic [15:0] code_out;
  logic        sdout;
  logic [3:0]  range_onehot;
  logic        range_is_current;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] ds = '0;

  always #5 clk = ~clk;

  serial_dac_loader uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .sclk_in          (sclk_in),
    .sdin_in          (sdin_in),
    .latch_in         (latch_in),
    .clr_in           (clr_in),
    .range_sel        (range_sel),
    .code_out         (code_out),
    .sdout            (sdout),
    .range_onehot     (range_onehot),
    .range_is_current (range_is_current)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Downstream model samples sdout right before each rising shift clock
  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sdin_in = v[i];
      repeat (HALF) @(negedge clk);
      ds = {ds[14:0], sdout};
      sclk_in = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk_in = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk);
    latch_in = 1'b1;
    repeat (HALF) @(negedge clk);
    latch_in = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    logic [15:0] prev;
    logic [15:0] w;
    logic [31:0] long_v;
    repeat (3) @(negedge clk);
    check("R1 code after reset", {16'h0, code_out}, 32'h0);
    check("R1 sdout after reset", {31'h0, sdout}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R4 sweep: walking ones then mixed patterns
    prev = 16'h0000;
    for (int k = 0; k < 22; k++) begin
      if (k < 16) w = 16'h1 << k;
      else w = 16'hA5C3 ^ (16'h1357 * k[15:0]);
      shift_bits({16'h0, w}, 16);
      check("R4 cascade gets previous word", {16'h0, ds}, {16'h0, prev});
      check("R4 sdout is top shifted bit", {31'h0, sdout}, {31'h0, w[15]});
      strobe();
      check("R2 loaded code", {16'h0, code_out}, {16'h0, w});
      prev = w;
    end

    // R3: shifting without strobe keeps the code
    shift_bits(32'h0000_3C3C, 16);
    check("R3 code held during shifting", {16'h0, code_out}, {16'h0, prev});

    // R8: 20 bits shifted, last 16 kept
    long_v = 32'h000F_1234;
    shift_bits(long_v, 20);
    strobe();
    check("R8 oldest bits dropped", {16'h0, code_out}, {16'h0, long_v[15:0]});

    // R5: clear acts between clock edges
    @(negedge clk);
    #2 clr_in = 1'b1;
    #1 check("R5 asynchronous clear", {16'h0, code_out}, 32'h0);

    // R6: strobe during clear ignored, shift contents kept
    shift_bits(32'h0000_BEEF, 16);
    strobe();
    check("R5 code zero while clear", {16'h0, code_out}, 32'h0);
    @(negedge clk);
    clr_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 strobe during clear ignored", {16'h0, code_out}, 32'h0);
    strobe();
    check("R6 shift contents kept", {16'h0, code_out}, 32'h0000_BEEF);

    // R7: span decode sweep
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      range_sel = s[1:0];
      #1;
      check("R7 onehot span", {28'h0, range_onehot}, 32'h1 << s);
      check("R7 current flag", {31'h0, range_is_current}, {31'h0, (s != 0)});
    end
    check("R3 code unaffected by span", {16'h0, code_out}, 32'h0000_BEEF);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule